// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This engine sits between a receive byte stream and a ring of receive descriptors in shared memory. Each frame arrives as bytes marked with start and end, and the last byte carries the CRC and framing error indications. When a frame starts, the engine reads the current descriptor through a synchronous 16-bit word port. If the controller owns that descriptor, the engine stores the bytes into its buffer. When a buffer fills before the frame ends, the engine chains into the next descriptor. At the end of the frame it writes the byte count into the last descriptor, then writes the status byte, which hands the descriptor back to the host.

A descriptor takes four consecutive words. Word 0 holds the low 16 bits of the buffer byte address. Word 1 holds the status byte in bits 15:8 and the high byte of the buffer address in bits 7:0. Word 2 holds the buffer size as a negated value. Word 3 holds the message length. Descriptor i sits at the ring base word address plus 4·i. The ring holds 2^`cfg_ring_log` entries. Buffer bytes are big-endian within a word: an even byte address maps to bits 15:8.

The host learns of results through two single-cycle events. `rx_int` marks a returned frame. `miss_int` marks a frame discarded because no buffer was available.

Top module: `rxr_ring_writer`

## Requirements
- R1: When a frame starts and the current descriptor has bit 7 of its status byte set (controller-owned), its bytes are stored in arrival order from the buffer's byte address onward. An even byte address uses bits 15:8 of the word (byte enable 2'b10) and an odd one uses bits 7:0 (byte enable 2'b01).
- R2: The buffer capacity is the low 12 bits of the two's-complement negation of word 2. For example, 16'hFFF8 gives 8 bytes. No more than that many bytes go into one buffer.
- R3: The final descriptor of a frame receives its message length in word 3 (write with byte enable 2'b11). The length is the total frame byte count, CRC bytes included. Its status byte then gets end-of-packet (bit 0) set and ownership (bit 7) cleared. A CRC error sets bit 3, a framing error sets bit 5, and either one also sets error summary (bit 6).
- R4: A frame longer than one buffer continues into the following descriptors. Start-of-packet (bit 1) is set only in the first descriptor of the frame. Descriptors before the last get a status byte of 8'h02 (first) or 8'h00 (others), and their word 3 is not written.
- R5: Every status byte is written through word 1 with byte enable 2'b10. On the final descriptor, this write follows the length write on the next cycle.
- R6: If the current descriptor is host-owned when a frame starts, the whole frame is accepted and discarded. No memory write occurs, the ring index does not move, and `miss_int` pulses once.
- R7: If the next descriptor of a chain is host-owned, the descriptor being filled is closed with buffer error (bit 2), error summary (bit 6) and start-of-packet if it was first. Its word 3 is not written, the rest of the frame is discarded, and the index moves past the closed descriptor. `rx_int` pulses once and `miss_int` does not.
- R8: `rx_int` is a one-cycle pulse in the cycle after the status write that returns the final descriptor of a frame.
- R9: The ring index advances by one per returned descriptor and wraps modulo 2^`cfg_ring_log`. Descriptor i is addressed at `cfg_ring_base` + 4·i.
- R10: A frame that exactly fills its buffer is closed in that descriptor, and the next descriptor is not written.
- R11: After reset, no memory request or event is active, the ring index is 0, and the stream is accepted only while no frame start is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | ADDR_W-1 | Word address of descriptor 0 |
| cfg_ring_log | input | 3 | Log2 of the ring entry count |
| rx_valid | input | 1 | Stream byte present |
| rx_ready | output | 1 | Stream byte taken this cycle |
| rx_data | input | 8 | Stream byte |
| rx_sop | input | 1 | First byte of a frame |
| rx_eop | input | 1 | Last byte of a frame |
| rx_crc_err | input | 1 | CRC error, valid with rx_eop |
| rx_fram_err | input | 1 | Framing error, valid with rx_eop |
| mem_rd | output | 1 | Word read request |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | ADDR_W-1 | Word address |
| mem_be | output | 2 | Byte enables, bit 1 = bits 15:8 |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| rx_int | output | 1 | Frame returned event |
| miss_int | output | 1 | Frame missed event |

## Verification
The last byte of a frame is taken at edge E. The length write then appears after E+1, the status write after E+2, and `rx_int` after E+3. A descriptor fetch issues three reads and decides six edges after the frame start is seen, so `miss_int` appears after the sixth edge. The scoreboard does not pin these cycles one by one. It compares every descriptor-area write, in the order it appears, against a queue of expected address, byte enable and data, which also checks the order of length and status writes. Buffer contents and event counts are checked only after a 30-cycle settle, well past the latest result.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECIDE, S_FILL, S_CLOSE_LEN, S_CLOSE_FLAG, S_POST, S_DROP
  } rxr_state_t;

  // status byte bit positions (decoded by host software)
  localparam int FB_OWN  = 7;
  localparam int FB_ERR  = 6;
  localparam int FB_FRAM = 5;
  localparam int FB_OFLO = 4;
  localparam int FB_CRC  = 3;
  localparam int FB_BUFF = 2;
  localparam int FB_STP  = 1;
  localparam int FB_ENP  = 0;

  // word offsets inside one descriptor
  localparam logic [1:0] OFF_BLO  = 2'd0;
  localparam logic [1:0] OFF_FLAG = 2'd1;
  localparam logic [1:0] OFF_BLEN = 2'd2;
  localparam logic [1:0] OFF_MLEN = 2'd3;
endpackage

// File: rtl/rxr_ring_addr.sv
module rxr_ring_addr #(
  parameter int WA_W  = 23,
  parameter int IDX_W = 7
) (
  input  logic [WA_W-1:0]  base,
  input  logic [IDX_W-1:0] idx,
  input  logic [2:0]       ring_log,
  input  logic [1:0]       off,
  output logic [WA_W-1:0]  waddr,
  output logic [IDX_W-1:0] nidx
);
  logic [IDX_W:0]   span;
  logic [IDX_W-1:0] mask;

  assign span  = (IDX_W+1)'(1) << ring_log;
  assign mask  = IDX_W'(span - 1'b1);
  assign nidx  = (idx + 1'b1) & mask;
  assign waddr = base + WA_W'({idx, off});
endmodule

// File: rtl/rxr_lane_pack.sv
module rxr_lane_pack (
  input  logic [7:0]  byte_in,
  input  logic        odd,
  output logic [1:0]  be,
  output logic [15:0] wdata
);
  assign be    = odd ? 2'b01 : 2'b10;
  assign wdata = {byte_in, byte_in};
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 7,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-2:0] cfg_ring_base,
  input  logic [2:0]        cfg_ring_log,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic              rx_crc_err,
  input  logic              rx_fram_err,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              rx_int,
  output logic              miss_int
);
  localparam int WA_W = ADDR_W - 1;

  rxr_state_t       state;
  logic [IDX_W-1:0] cur_idx, fidx, idx_sel, ring_nidx;
  logic [2:0]       k;
  logic             have_cur, cur_first, trunc;
  logic [LEN_W-1:0] cnt, cap, tot, n_blen;
  logic [ADDR_W-1:0] cur_base, baddr;
  logic             n_own;
  logic [7:0]       n_bhi, fl, fin_fl, flag_byte, lane_byte;
  logic [15:0]      n_blo;
  logic [23:0]      nb;
  logic [1:0]       off_sel, lane_be;
  logic [WA_W-1:0]  ring_waddr;
  logic [15:0]      lane_wdata;
  logic             lane_odd;

  assign nb      = {n_bhi, n_blo};
  assign baddr   = cur_base + ADDR_W'(cnt);
  assign idx_sel = (state == S_FETCH) ? fidx : cur_idx;

  always_comb begin
    if (state == S_FETCH)
      off_sel = (k == 3'd0) ? OFF_FLAG : (k == 3'd1) ? OFF_BLO : OFF_BLEN;
    else if (state == S_CLOSE_LEN)
      off_sel = OFF_MLEN;
    else
      off_sel = OFF_FLAG;
  end

  rxr_ring_addr #(.WA_W(WA_W), .IDX_W(IDX_W)) u_ring_addr (
    .base(cfg_ring_base), .idx(idx_sel), .ring_log(cfg_ring_log),
    .off(off_sel), .waddr(ring_waddr), .nidx(ring_nidx)
  );

  // final status byte built from the error inputs on the last byte
  always_comb begin
    fin_fl          = '0;
    fin_fl[FB_ENP]  = 1'b1;
    fin_fl[FB_STP]  = cur_first;
    fin_fl[FB_CRC]  = rx_crc_err;
    fin_fl[FB_FRAM] = rx_fram_err;
    fin_fl[FB_ERR]  = rx_crc_err | rx_fram_err;
  end

  assign flag_byte = (state == S_DECIDE) ? {6'b0, cur_first, 1'b0} : fl;
  assign lane_byte = (state == S_FILL) ? rx_data : flag_byte;
  assign lane_odd  = (state == S_FILL) ? baddr[0] : 1'b0;

  rxr_lane_pack u_lane (
    .byte_in(lane_byte), .odd(lane_odd), .be(lane_be), .wdata(lane_wdata)
  );

  always_comb begin
    case (state)
      S_IDLE:  rx_ready = !rx_sop;
      S_FILL:  rx_ready = (cnt < cap);
      S_DROP:  rx_ready = 1'b1;
      default: rx_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cur_idx <= '0; fidx <= '0; k <= '0;
      have_cur <= 1'b0; cur_first <= 1'b0; trunc <= 1'b0;
      cnt <= '0; cap <= '0; tot <= '0; n_blen <= '0; cur_base <= '0;
      n_own <= 1'b0; n_bhi <= '0; n_blo <= '0; fl <= '0;
      mem_rd <= 1'b0; mem_wr <= 1'b0; mem_addr <= '0; mem_be <= '0;
      mem_wdata <= '0; rx_int <= 1'b0; miss_int <= 1'b0;
    end else begin
      mem_rd <= 1'b0; mem_wr <= 1'b0; rx_int <= 1'b0; miss_int <= 1'b0;
      case (state)
        S_IDLE: if (rx_valid && rx_sop) begin
          fidx <= cur_idx; k <= '0; have_cur <= 1'b0; tot <= '0;
          trunc <= 1'b0; state <= S_FETCH;
        end
        S_FETCH: begin
          if (k <= 3'd2) begin mem_rd <= 1'b1; mem_addr <= ring_waddr; end
          if (k == 3'd2) begin n_own <= mem_rdata[15]; n_bhi <= mem_rdata[7:0]; end
          if (k == 3'd3) n_blo <= mem_rdata;
          if (k == 3'd4) begin n_blen <= mem_rdata[LEN_W-1:0]; state <= S_DECIDE; end
          k <= k + 3'd1;
        end
        S_DECIDE: if (n_own) begin
          if (have_cur) begin
            mem_wr <= 1'b1; mem_addr <= ring_waddr;
            mem_be <= lane_be; mem_wdata <= lane_wdata;
          end
          cur_idx <= fidx; cur_base <= nb[ADDR_W-1:0];
          cap <= ~n_blen + 1'b1; cnt <= '0;
          cur_first <= !have_cur; have_cur <= 1'b1; state <= S_FILL;
        end else if (have_cur) begin
          fl <= {1'b0, 1'b1, 3'b000, 1'b1, cur_first, 1'b0};
          trunc <= 1'b1; state <= S_CLOSE_FLAG;
        end else begin
          miss_int <= 1'b1; state <= S_DROP;
        end
        S_FILL: if (rx_valid && (cnt < cap)) begin
          mem_wr <= 1'b1; mem_addr <= baddr[ADDR_W-1:1];
          mem_be <= lane_be; mem_wdata <= lane_wdata;
          cnt <= cnt + 1'b1; tot <= tot + 1'b1;
          if (rx_eop) begin fl <= fin_fl; state <= S_CLOSE_LEN; end
        end else if (rx_valid) begin
          fidx <= ring_nidx; k <= '0; state <= S_FETCH;
        end
        S_CLOSE_LEN: begin
          mem_wr <= 1'b1; mem_addr <= ring_waddr; mem_be <= 2'b11;
          mem_wdata <= 16'(tot); state <= S_CLOSE_FLAG;
        end
        S_CLOSE_FLAG: begin
          mem_wr <= 1'b1; mem_addr <= ring_waddr;
          mem_be <= lane_be; mem_wdata <= lane_wdata;
          cur_idx <= ring_nidx; have_cur <= 1'b0; state <= S_POST;
        end
        S_POST: begin
          rx_int <= 1'b1; state <= trunc ? S_DROP : S_IDLE;
        end
        S_DROP: if (rx_valid && rx_eop) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: the word port never reads and writes in one cycle
  assert_no_rd_wr_clash_R1: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  // R2: a buffer is never filled past its capacity
  assert_fill_within_cap_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FILL) |-> (cnt <= cap));
  // R5: a length write is followed at once by a status-byte write
  assert_flag_after_len_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_be == 2'b11) |=> (mem_wr && mem_be == 2'b10));
  // R6: a missed frame causes no memory write, and dropping stays silent
  assert_miss_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (miss_int || state == S_DROP) |-> !mem_wr);
  // R8: the frame event is one cycle wide and follows a status write
  assert_int_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rx_int |=> !rx_int);
  assert_int_after_flag_R8: assert property (@(posedge clk) disable iff (rst)
    rx_int |-> ($past(mem_wr) && $past(mem_be) == 2'b10));
endmodule

// File: tb/rxr_ring_writer_bench.sv
module rxr_ring_writer_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int WA_W   = ADDR_W - 1;

  typedef struct packed {
    logic [WA_W-1:0] a;
    logic [1:0]      be;
    logic [15:0]     d;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WA_W-1:0] cfg_ring_base = '0;
  logic [2:0] cfg_ring_log = 3'd2;
  logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic rx_crc_err = 1'b0, rx_fram_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, mem_rd, mem_wr, rx_int, miss_int;
  logic [WA_W-1:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem [0:(1<<WA_W)-1];
  logic ini_we = 1'b0;
  logic [WA_W-1:0] ini_a = '0;
  logic [15:0] ini_d = '0;

  int checks = 0, fails = 0, nint = 0, nmiss = 0, ndata = 0;
  exp_t q[$];
  string qt[$];

  always #(CLK_P/2) clk = ~clk;

  rxr_ring_writer #(.ADDR_W(ADDR_W)) u_rxr_ring_writer (
    .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base), .cfg_ring_log(cfg_ring_log),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_crc_err(rx_crc_err), .rx_fram_err(rx_fram_err),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_int(rx_int), .miss_int(miss_int)
  );

  // shared memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (ini_we) mem[ini_a] <= ini_d;
    else if (mem_wr) begin
      if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
      if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: descriptor-area writes are popped in order
  always @(negedge clk) if (!rst) begin
    if (rx_int) nint++;
    if (miss_int) nmiss++;
    if (mem_wr) begin
      if (mem_addr < WA_W'(16)) begin
        if (q.size() == 0)
          check(1'b0, "R5", "unexpected descriptor write at", int'(mem_addr), -1);
        else begin
          exp_t e;
          string t;
          logic [15:0] m;
          e = q.pop_front();
          t = qt.pop_front();
          m = {{8{e.be[1]}}, {8{e.be[0]}}};
          check(mem_addr == e.a, t, "desc write address", int'(mem_addr), int'(e.a));
          check(mem_be == e.be, t, "desc write enables", int'(mem_be), int'(e.be));
          check((mem_wdata & m) == (e.d & m), t, "desc write data",
                int'(mem_wdata & m), int'(e.d & m));
        end
      end else ndata++;
    end
  end

  task automatic poke(input int a, input logic [15:0] d);
    @(negedge clk);
    ini_we = 1'b1; ini_a = WA_W'(a); ini_d = d;
    @(posedge clk); #1;
    ini_we = 1'b0;
  endtask

  task automatic init_desc(input int i, input int cap, input bit own);
    poke(i*4,   16'(16'h0100 + i*16'h0080));
    poke(i*4+1, {own ? 8'h80 : 8'h00, 8'h00});
    poke(i*4+2, 16'(16'hF000 | (16'h0000 - 16'(cap))));
    poke(i*4+3, 16'hBEEF);
  endtask

  task automatic exp_w(input int a, input logic [1:0] be, input logic [15:0] d,
                       input string tag);
    exp_t e;
    e.a = WA_W'(a); e.be = be; e.d = d;
    q.push_back(e); qt.push_back(tag);
  endtask

  task automatic exp_flag(input int i, input logic [7:0] f, input string tag);
    exp_w(i*4+1, 2'b10, {f, 8'h00}, tag);
  endtask

  task automatic exp_final(input int i, input int len, input logic [7:0] f,
                           input string tag);
    exp_w(i*4+3, 2'b11, 16'(len), tag);
    exp_flag(i, f, tag);
  endtask

  task automatic send(input int n, input logic [7:0] seed, input bit crc, input bit fram);
    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      bit acc;
      rx_valid = 1'b1; rx_data = 8'(seed + j);
      rx_sop = (j == 0); rx_eop = (j == n-1);
      rx_crc_err = (j == n-1) && crc; rx_fram_err = (j == n-1) && fram;
      do begin
        #1; acc = rx_ready;
        @(posedge clk); @(negedge clk);
      end while (!acc);
    end
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    rx_crc_err = 1'b0; rx_fram_err = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  function automatic logic [7:0] rbyte(input int ba);
    logic [15:0] w;
    w = mem[ba >> 1];
    return (ba % 2) ? w[7:0] : w[15:8];
  endfunction

  task automatic chk_data(input int ba, input int n, input logic [7:0] seed,
                          input string tag);
    for (int j = 0; j < n; j++)
      check(rbyte(ba+j) == 8'(seed + j), tag, "buffer byte", int'(rbyte(ba+j)),
            int'(8'(seed + j)));
  endtask

  task automatic chk_drained(input string tag);
    check(q.size() == 0, tag, "expected writes left", q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < (1<<WA_W); i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) init_desc(i, 64, 1'b1);
    @(negedge clk); rst = 1'b0;
    #1;
    // R11: idle after reset
    check(mem_wr == 0 && mem_rd == 0, "R11", "memory request after reset", mem_wr, 0);
    check(rx_int == 0 && miss_int == 0, "R11", "event after reset", rx_int, 0);
    check(rx_ready == 1, "R11", "ready while idle", rx_ready, 1);

    // R1, R3, R11: first frame lands in descriptor 0
    exp_final(0, 10, 8'h03, "R3");
    send(10, 8'h10, 0, 0);
    chk_data(16'h100, 10, 8'h10, "R1");
    check(nint == 1, "R8", "rx_int count", nint, 1);
    chk_drained("R3");

    // R3: CRC error sets bits 3 and 6
    exp_final(1, 12, 8'h4B, "R3");
    send(12, 8'h30, 1, 0);
    chk_data(16'h180, 12, 8'h30, "R3");
    // R3: framing error sets bits 5 and 6
    exp_final(2, 5, 8'h63, "R3");
    send(5, 8'h50, 0, 1);
    // R9: fourth descriptor, then wrap to 0
    exp_final(3, 7, 8'h03, "R9");
    send(7, 8'h70, 0, 0);
    check(nint == 4, "R8", "rx_int count", nint, 4);
    chk_drained("R9");

    // R2, R4: chain across three 8-byte buffers
    init_desc(0, 8, 1'b1); init_desc(1, 8, 1'b1); init_desc(2, 8, 1'b1);
    exp_flag(0, 8'h02, "R4");
    exp_flag(1, 8'h00, "R4");
    exp_final(2, 20, 8'h01, "R4");
    send(20, 8'h90, 0, 0);
    chk_data(16'h100, 8, 8'h90, "R2");
    chk_data(16'h180, 8, 8'h98, "R2");
    chk_data(16'h200, 4, 8'hA0, "R2");
    check(mem[3] == 16'hBEEF, "R4", "first length word touched", int'(mem[3]), 16'hBEEF);
    check(mem[7] == 16'hBEEF, "R4", "middle length word touched", int'(mem[7]), 16'hBEEF);
    check(nint == 5, "R8", "one rx_int per chained frame", nint, 5);
    chk_drained("R4");

    // R6: descriptor 3 host-owned -> missed frame
    init_desc(3, 8, 1'b0);
    begin
      int d0;
      d0 = ndata;
      send(6, 8'hB0, 0, 0);
      check(nmiss == 1, "R6", "miss_int count", nmiss, 1);
      check(ndata == d0, "R6", "data writes on missed frame", ndata - d0, 0);
      check(nint == 5, "R6", "rx_int on missed frame", nint, 5);
      check(mem[15] == 16'hBEEF, "R6", "length word touched", int'(mem[15]), 16'hBEEF);
    end
    chk_drained("R6");

    // R7: descriptor 3 usable, descriptor 0 host-owned -> truncation
    init_desc(3, 8, 1'b1); init_desc(0, 8, 1'b0);
    exp_flag(3, 8'h46, "R7");
    send(12, 8'hC0, 0, 0);
    chk_data(16'h280, 8, 8'hC0, "R7");
    check(mem[15] == 16'hBEEF, "R7", "truncated length word touched", int'(mem[15]), 16'hBEEF);
    check(nint == 6, "R7", "rx_int count", nint, 6);
    check(nmiss == 1, "R7", "miss_int on truncation", nmiss, 1);
    chk_drained("R7");

    // R10: exact fill, index now 0 (moved past closed descriptor 3)
    init_desc(0, 8, 1'b1); init_desc(1, 64, 1'b1);
    exp_final(0, 8, 8'h03, "R10");
    send(8, 8'hD0, 0, 0);
    chk_data(16'h100, 8, 8'hD0, "R10");
    check(mem[5] == 16'h8000, "R10", "next status word touched", int'(mem[5]), 16'h8000);
    chk_drained("R10");

    // R9: two-entry ring, index 1 wraps to 0
    @(negedge clk); cfg_ring_log = 3'd1;
    exp_final(1, 4, 8'h03, "R9");
    send(4, 8'hE0, 0, 0);
    init_desc(0, 64, 1'b1);
    exp_final(0, 3, 8'h03, "R9");
    send(3, 8'hF0, 0, 0);
    chk_data(16'h100, 3, 8'hF0, "R9");
    check(nint == 9, "R8", "rx_int total", nint, 9);
    chk_drained("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule